// File: doc/BRIEF.md
# Adaptive Minimum On-Time Inversion Guard

This block holds the gate timing of one synchronous-rectifier channel. It times the conduction of each switching period, from the rising gate to the first sample of the drain-high comparator. It then turns that time into a turn-off blanking interval for the next period. While blanking is active the ordinary turn-off comparator has no effect. Only a debounced reverse-current condition can end the pulse early. Such an early end also raises a delayed-turn-on flag.

While the flag is set, turn-on needs a longer qualification time, and the blanking ratio drops from one half to about one fifth. The flag clears after a long run of clean switching periods. A clean period is one in which the drain crossed below the turn-on threshold exactly once before the gate came on. The block runs on a 100 MHz clock. The analog comparators and the gate driver sit outside it.

Top module: `sr_blank_guard`

## Requirements
- R1: After reset the gate request and the delay flag are both 0, the block is armed, and the stored conduction time is 0, so the first pulse uses the 20-clock floor.
- R2: With the delay flag low, an armed block whose turn-on comparator is sampled high raises the gate one clock later. The block is armed at reset and again each time the drain-high comparator is sampled high, and each turn-on disarms it.
- R3: With the delay flag high, the turn-on comparator must be sampled high on 24 consecutive clocks before the gate rises. A shorter pulse leaves the gate low.
- R4: The conduction time equals the number of clocks from the first clock the gate is high to the first clock the drain-high comparator is sampled high. A value of 0 is possible.
- R5: The blanking length M comes from the previous conduction time P. With the flag low M = P>>1; with the flag high M = (P>>3)+(P>>4)+(P>>7)+(P>>8). M is then clamped to at least 20 clocks and to at most 500 (flag low) or 250 (flag high). The turn-off comparator is ignored during the first M gate-high clocks, so a turn-off comparator held high from turn-on gives a gate pulse of exactly M+1 clocks.
- R6: If the inversion condition holds on 32 consecutive blanking clocks, the gate falls on the next clock and the delay flag sets in the same clock. A condition held from turn-on therefore gives a 32-clock pulse when M is at least 32. When M is below 32 there is no trip.
- R7: While the flag is high, each turn-on counts the period as clean when exactly one rising edge of the turn-on comparator was seen while armed and idle. Any other count resets the clean-period counter, and so does an inversion trip. The flag clears at the turn-on that completes RECOV_CYCLES consecutive clean periods (default 16384).
- R8: While the run enable is low, the gate is cleared at the next clock and no turn-on occurs.
- R9: The inversion condition is the zero-volt comparator when the light-load code is 0, and the turn-off comparator when the code is nonzero. With code 0, a turn-off comparator held high through blanking causes no trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Run enable; low forces the gate off |
| on_cmp | input | 1 | Drain below turn-on threshold |
| off_cmp | input | 1 | Drain above virtual turn-off threshold |
| high_cmp | input | 1 | Drain above the high-detect threshold |
| zero_cmp | input | 1 | Drain above zero volts |
| lld | input | 2 | Light-load code, 0 = normal load |
| gate_o | output | 1 | Gate request |
| dly_o | output | 1 | Delayed-turn-on flag |

## Verification
The bench drives switching periods with random conduction times and checks each pulse width against the blanking length predicted from the previous period. This tells the half ratio from the fifth ratio, and both from the floor and the two ceilings. Periods that hold the inversion input high through blanking are run with long and short predicted blanking and with both light-load codes. These separate a genuine trip from a normal turn-off, and separate the zero comparator from the threshold comparator as the inversion source. Short turn-on pulses, doubled crossings and runs of clean periods show apart the qualification delay, the counter reset and the exact period on which the flag clears.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
   localparam int unsigned CLK_MHZ = 100;

   typedef enum logic [1:0] {
      LOAD_NORMAL  = 2'd0,
      LOAD_LIGHT   = 2'd1,
      LOAD_LIGHTER = 2'd2,
      LOAD_RSVD    = 2'd3
   } load_lvl_e;

   // nanoseconds to whole clock periods, rounded up
   function automatic int unsigned ns_to_cyc(input int unsigned ns);
      return (ns * CLK_MHZ + 999) / 1000;
   endfunction
endpackage

// File: rtl/sbg_cond_meter.sv
module sbg_cond_meter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         high_cmp,
   output logic [W-1:0] prev_cond
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   logic         meas_q;
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meas_q    <= 1'b0;
         cnt_q     <= '0;
         prev_cond <= '0;
      end else if (start) begin
         meas_q <= 1'b1;
         cnt_q  <= '0;
      end else if (meas_q) begin
         if (high_cmp) begin
            prev_cond <= cnt_q;
            meas_q    <= 1'b0;
         end else if (cnt_q != MAXV) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sbg_minon_scale.sv
module sbg_minon_scale #(
   parameter int unsigned W        = 16,
   parameter logic [31:0] MASK_LO  = 32'h2,
   parameter logic [31:0] MASK_HI  = 32'h198,
   parameter int unsigned FLOOR    = 20,
   parameter int unsigned CEIL_LO  = 500,
   parameter int unsigned CEIL_HI  = 250
) (
   input  logic [W-1:0] prev_cond,
   input  logic         slow_mode,
   output logic [W-1:0] minon
);
   localparam logic [W:0] FLOOR_V = (W+1)'(FLOOR);
   localparam logic [W:0] CLO_V   = (W+1)'(CEIL_LO);
   localparam logic [W:0] CHI_V   = (W+1)'(CEIL_HI);

   logic [W:0] t_lo [W];
   logic [W:0] t_hi [W];
   logic [W:0] sum_lo, sum_hi, sel, ceil_v;

   for (genvar g = 0; g < W; g++) begin : g_term
      assign t_lo[g] = MASK_LO[g] ? (W+1)'(prev_cond >> g) : '0;
      assign t_hi[g] = MASK_HI[g] ? (W+1)'(prev_cond >> g) : '0;
   end

   always_comb begin
      sum_lo = '0;
      sum_hi = '0;
      for (int i = 0; i < int'(W); i++) begin
         sum_lo = sum_lo + t_lo[i];
         sum_hi = sum_hi + t_hi[i];
      end
      sel    = slow_mode ? sum_hi : sum_lo;
      ceil_v = slow_mode ? CHI_V : CLO_V;
      if (sel < FLOOR_V)      minon = W'(FLOOR_V);
      else if (sel > ceil_v)  minon = W'(ceil_v);
      else                    minon = W'(sel);
   end
endmodule

// File: rtl/sbg_debounce.sv
module sbg_debounce #(
   parameter int unsigned LEN = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   output logic hit
);
   localparam int unsigned CW = $clog2(LEN + 1);
   localparam logic [CW-1:0] LAST = CW'(LEN - 1);

   logic [CW-1:0] cnt_q;

   assign hit = cond && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!cond)   cnt_q <= '0;
      else if (!hit)    cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sbg_recovery.sv
module sbg_recovery #(
   parameter int unsigned TARGET = 16384
) (
   input  logic clk,
   input  logic rst_n,
   input  logic on_cmp,
   input  logic watch,
   input  logic turn_on,
   input  logic dly,
   input  logic inv_trip,
   output logic rec_done
);
   localparam int unsigned RW = $clog2(TARGET + 1);
   localparam logic [RW-1:0] LAST = RW'(TARGET - 1);

   logic          on_q;
   logic [1:0]    xcnt_q, xeff;
   logic          edge_now, clean;
   logic [RW-1:0] rec_q;

   assign edge_now = watch && on_cmp && !on_q;

   always_comb begin
      xeff = xcnt_q;
      if (edge_now && xcnt_q != 2'd2) xeff = xcnt_q + 2'd1;
   end

   assign clean    = (xeff == 2'd1);
   assign rec_done = turn_on && dly && clean && (rec_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q   <= 1'b0;
         xcnt_q <= 2'd0;
         rec_q  <= '0;
      end else begin
         on_q <= on_cmp;
         if (turn_on) xcnt_q <= 2'd0;
         else         xcnt_q <= xeff;
         if (inv_trip)                 rec_q <= '0;
         else if (turn_on && dly) begin
            if (!clean || rec_done)    rec_q <= '0;
            else                       rec_q <= rec_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sr_blank_guard.sv
module sr_blank_guard
   import sbg_pkg::*;
#(
   parameter int unsigned MEAS_W        = 16,
   parameter int unsigned FLOOR_NS      = 200,
   parameter int unsigned CEIL_LO_NS    = 5000,
   parameter int unsigned CEIL_HI_NS    = 2500,
   parameter int unsigned INV_DEB_NS    = 320,
   parameter int unsigned ON_QUAL_NS    = 240,
   parameter int unsigned RECOV_CYCLES  = 16384,
   parameter logic [31:0] RATIO_LO_MASK = 32'h2,
   parameter logic [31:0] RATIO_HI_MASK = 32'h198
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_en,
   input  logic       on_cmp,
   input  logic       off_cmp,
   input  logic       high_cmp,
   input  logic       zero_cmp,
   input  logic [1:0] lld,
   output logic       gate_o,
   output logic       dly_o
);
   localparam int unsigned FLOOR_CYC   = ns_to_cyc(FLOOR_NS);
   localparam int unsigned CEIL_LO_CYC = ns_to_cyc(CEIL_LO_NS);
   localparam int unsigned CEIL_HI_CYC = ns_to_cyc(CEIL_HI_NS);
   localparam int unsigned INV_CYC     = ns_to_cyc(INV_DEB_NS);
   localparam int unsigned QUAL_CYC    = ns_to_cyc(ON_QUAL_NS);

   if (MEAS_W < 4 || MEAS_W > 32) begin : g_bad_width
      $error("MEAS_W must lie in 4..32");
   end
   if (FLOOR_CYC < 1 || FLOOR_CYC > CEIL_HI_CYC || FLOOR_CYC > CEIL_LO_CYC) begin : g_bad_floor
      $error("floor must be nonzero and below both ceilings");
   end
   if (CEIL_LO_CYC >= (64'd1 << MEAS_W) || CEIL_HI_CYC >= (64'd1 << MEAS_W)) begin : g_bad_ceil
      $error("ceilings must fit the measurement width");
   end
   if (INV_CYC < 1 || QUAL_CYC < 1 || RECOV_CYCLES < 1) begin : g_bad_count
      $error("debounce, qualification and recovery counts must be nonzero");
   end

   logic              gate_q, dly_q, armed_q;
   logic [MEAS_W-1:0] blank_q, prev_cond, minon;
   logic              blanking, inv_cond, inv_hit, inv_trip;
   logic              qual_cond, qual_hit, turn_on, norm_off, rec_done;

   assign blanking  = gate_q && (blank_q != '0);
   assign inv_cond  = (load_lvl_e'(lld) == LOAD_NORMAL) ? zero_cmp : off_cmp;
   assign inv_trip  = blanking && inv_hit;
   assign qual_cond = !gate_q && run_en && armed_q && on_cmp;
   assign turn_on   = qual_cond && (!dly_q || qual_hit);
   assign norm_off  = gate_q && (blank_q == '0) && off_cmp;

   sbg_cond_meter #(.W(MEAS_W)) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (turn_on),
      .high_cmp  (high_cmp),
      .prev_cond (prev_cond)
   );

   sbg_minon_scale #(
      .W       (MEAS_W),
      .MASK_LO (RATIO_LO_MASK),
      .MASK_HI (RATIO_HI_MASK),
      .FLOOR   (FLOOR_CYC),
      .CEIL_LO (CEIL_LO_CYC),
      .CEIL_HI (CEIL_HI_CYC)
   ) u_scale (
      .prev_cond (prev_cond),
      .slow_mode (dly_q),
      .minon     (minon)
   );

   sbg_debounce #(.LEN(INV_CYC)) u_inv_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (blanking && inv_cond),
      .hit   (inv_hit)
   );

   sbg_debounce #(.LEN(QUAL_CYC)) u_on_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (qual_cond),
      .hit   (qual_hit)
   );

   sbg_recovery #(.TARGET(RECOV_CYCLES)) u_recov (
      .clk      (clk),
      .rst_n    (rst_n),
      .on_cmp   (on_cmp),
      .watch    (armed_q && !gate_q && run_en),
      .turn_on  (turn_on),
      .dly      (dly_q),
      .inv_trip (inv_trip),
      .rec_done (rec_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q  <= 1'b0;
         dly_q   <= 1'b0;
         armed_q <= 1'b1;
         blank_q <= '0;
      end else begin
         if (!run_en)                  gate_q <= 1'b0;
         else if (turn_on)             gate_q <= 1'b1;
         else if (inv_trip || norm_off) gate_q <= 1'b0;

         if (turn_on)       armed_q <= 1'b0;
         else if (high_cmp) armed_q <= 1'b1;

         if (turn_on)       blank_q <= minon;
         else if (blanking) blank_q <= blank_q - 1'b1;

         if (inv_trip)      dly_q <= 1'b1;
         else if (rec_done) dly_q <= 1'b0;
      end
   end

   assign gate_o = gate_q;
   assign dly_o  = dly_q;
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
   parameter int unsigned FLOOR_CYC = 20
) (
   input logic clk,
   input logic rst_n,
   input logic run_en,
   input logic on_cmp,
   input logic gate_o,
   input logic dly_o
);
   logic [15:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  hi_cnt <= '0;
      else if (!gate_o)            hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
   end

   p_run_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !gate_o);

   p_on_needs_cmp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o) |-> $past(on_cmp));

   p_dly_set_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dly_o) |-> $fell(gate_o));

   p_dly_clear_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dly_o) |-> $rose(gate_o));

   p_min_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gate_o) && $past(run_en)) |-> (hi_cnt >= 16'(FLOOR_CYC + 1)));
endmodule

bind sr_blank_guard sbg_checker #(.FLOOR_CYC(FLOOR_CYC)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .run_en (run_en),
   .on_cmp (on_cmp),
   .gate_o (gate_o),
   .dly_o  (dly_o)
);

// File: tb/sim_sr_blank_guard.sv
module sim_sr_blank_guard;
   localparam int CLK_PERIOD = 10;
   localparam int RB         = 12;
   localparam int WD_CYCLES  = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_en = 1'b1;
   logic       on_cmp = 1'b0, off_cmp = 1'b0, high_cmp = 1'b0, zero_cmp = 1'b0;
   logic [1:0] lld = 2'd0;
   logic       gate_o, dly_o;

   int  checks = 0, failures = 0;
   bit  done = 1'b0;
   int  m_prev = 0, m_rec = 0;
   bit  m_dly = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sr_blank_guard #(.RECOV_CYCLES(RB)) u0 (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .on_cmp(on_cmp),
      .off_cmp(off_cmp), .high_cmp(high_cmp), .zero_cmp(zero_cmp),
      .lld(lld), .gate_o(gate_o), .dly_o(dly_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_minon(input int p, input bit slow);
      int s, c;
      s = slow ? (p >> 3) + (p >> 4) + (p >> 7) + (p >> 8) : (p >> 1);
      c = slow ? 250 : 500;
      if (s < 20) s = 20;
      if (s > c)  s = c;
      return s;
   endfunction

   // one switching period; turn-off comparator held high from turn-on
   task automatic run_cycle(input int h, input bit zv, input bit glitch, input string req);
      int m, lat, hi, j, exp_lat;
      bit invc, trip, dly_on;
      if (glitch) begin
         on_cmp = 1'b1;
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(gate_o == 1'b0, "R3 short pulse", gate_o, 0);
         end
         on_cmp = 1'b0;
         repeat (3) @(negedge clk);
      end
      m       = exp_minon(m_prev, m_dly);
      exp_lat = m_dly ? 24 : 1;
      dly_on  = m_dly;
      if (m_dly) begin
         if (!glitch) begin
            m_rec++;
            if (m_rec == RB) begin dly_on = 1'b0; m_rec = 0; end
         end else m_rec = 0;
      end
      on_cmp = 1'b1;
      lat = 0;
      do begin @(negedge clk); lat++; end while (!gate_o && lat < 200);
      check(lat == exp_lat, m_dly ? "R3 latency" : "R2 latency", lat, exp_lat);
      check(dly_o == dly_on, "R7 flag at turn-on", dly_o, dly_on);
      m_dly = dly_on;
      invc  = (lld == 2'd0) ? zv : 1'b1;
      trip  = invc && (m >= 32);
      hi = 0; j = 0;
      while (j < 5000) begin
         if (gate_o) hi++;
         else if (j > h) break;
         on_cmp = 1'b0; off_cmp = 1'b1; zero_cmp = zv; high_cmp = (j >= h);
         @(negedge clk);
         j++;
      end
      check(hi == (trip ? 32 : m + 1), req, hi, trip ? 32 : m + 1);
      check(dly_o == (trip ? 1'b1 : m_dly), "R6 flag after pulse", dly_o, trip ? 1 : int'(m_dly));
      off_cmp = 1'b0; zero_cmp = 1'b0; high_cmp = 1'b0;
      repeat (3) @(negedge clk);
      m_prev = h;
      if (trip) begin m_dly = 1'b1; m_rec = 0; end
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd4242);
      repeat (4) @(negedge clk);
      check(gate_o == 1'b0, "R1 gate in reset", gate_o, 0);
      check(dly_o == 1'b0, "R1 flag in reset", dly_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_cycle($urandom_range(60, 260), 1'b0, 1'b0, "R1 floor on first pulse");
      for (int i = 0; i < 6; i++) run_cycle($urandom_range(0, 1300), 1'b0, 1'b0, "R5 R9 half ratio");
      run_cycle(1500, 1'b0, 1'b0, "R4 R5 width");
      run_cycle(100, 1'b0, 1'b0, "R5 ceiling 500");
      run_cycle(80, 1'b1, 1'b0, "R6 zero comparator trip");
      run_cycle(1500, 1'b0, 1'b0, "R3 R5 fifth ratio floor");
      run_cycle(400, 1'b0, 1'b0, "R5 ceiling 250");
      lld = 2'd1;
      run_cycle(100, 1'b0, 1'b0, "R9 threshold comparator trip");
      lld = 2'd0;
      for (int i = 0; i < 5; i++) run_cycle($urandom_range(20, 150), 1'($urandom_range(0, 1)), 1'b0, "R7 clean run");
      run_cycle(60, 1'b0, 1'b1, "R7 double crossing");
      for (int i = 0; i < RB; i++) run_cycle($urandom_range(20, 150), 1'($urandom_range(0, 1)), 1'b0, "R7 recovery");
      check(dly_o == 1'b0, "R7 flag cleared", dly_o, 0);
      run_cycle(120, 1'b0, 1'b0, "R2 R5 after recovery");

      on_cmp = 1'b1;
      @(negedge clk);
      check(gate_o == 1'b1, "R2 turn-on", gate_o, 1);
      run_en = 1'b0;
      @(negedge clk);
      check(gate_o == 1'b0, "R8 gate cleared", gate_o, 0);
      high_cmp = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check(gate_o == 1'b0, "R8 no turn-on", gate_o, 0);
      end
      high_cmp = 1'b0;
      run_en = 1'b1;
      @(negedge clk);
      check(gate_o == 1'b1, "R8 R2 resume", gate_o, 1);
      on_cmp = 1'b0; off_cmp = 1'b1;
      repeat (30) @(negedge clk);
      off_cmp = 1'b0;

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule